// File: doc/BRIEF.md
# Flow-Change Target Predictor

This block shortens instruction fetch after a change of control flow. It holds a small direct-mapped table. Each entry pairs the last fetch address seen before a flow change with the fetch address that came after it. The CPU side raises a hint one step before the program counter is about to jump. On that hint the block looks up the current fetch address. On a hit it offers the stored target to the prefetch path at once, so fetching can begin before the CPU drives its real address.

When the real target arrives, it is compared with the speculative one. A wrong guess raises a one-cycle restart pulse, and the table entry is rewritten with the observed target. A miss gives no prediction, so the prefetch path waits one extra clock for the real address; the observed pair is then stored so the next pass through the same branch can hit. A flush input invalidates the whole table, for use after code has been modified.

Top module: `flow_target_predictor`

## Requirements
- R1: While reset is held and after its release, `predict_valid_o` and `mispredict_o` are 0 and every table entry is invalid.
- R2: A lookup happens only on a cycle where `hint_i` is sampled high. The table slot is `pc_i[4:1]` for the default 16 entries. The tag is `pc_i[AW-1:5]`. The result appears on the outputs in the next cycle.
- R3: A lookup with no valid matching entry leaves `predict_valid_o` at 0. The following resolve produces no mispredict pulse and stores the pair (looked-up address → `target_i`).
- R4: A lookup that hits drives `predict_valid_o` high with `predict_addr_o` equal to the stored target. Both hold steady until a resolve or flush is sampled.
- R5: A resolve whose `target_i` equals the offered prediction gives no pulse and leaves the entry unchanged.
- R6: A resolve whose `target_i` differs from the offered prediction raises `mispredict_o` for exactly the next cycle. It also rewrites the entry in that same edge, so the next lookup of that address offers `target_i`.
- R7: Bit 0 of `pc_i` takes no part in the index or the tag, so two addresses that differ only in bit 0 share an entry.
- R8: An address with the same slot but a different tag misses. Training it replaces the slot's earlier occupant, which then misses.
- R9: `flush_i` invalidates every entry and cancels any outstanding lookup. Outputs go low in the next cycle, and a resolve after that has no effect.
- R10: A resolve sampled with no outstanding lookup is ignored: no pulse and no table write.
- R11: A hint sampled while a lookup is outstanding and no resolve arrives in that cycle is ignored. The offered prediction stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries and cancel the outstanding lookup |
| hint_i | input | 1 | Control flow is about to change; look up `pc_i` |
| pc_i | input | AW | Current fetch address used as the lookup key |
| resolve_i | input | 1 | The real post-change fetch address is on `target_i` |
| target_i | input | AW | Real fetch address after the flow change |
| predict_valid_o | output | 1 | A speculative target is being offered |
| predict_addr_o | output | AW | Speculative next fetch address |
| mispredict_o | output | 1 | One-cycle restart request after a wrong guess |

## Verification
The properties assume that `target_i` is meaningful only when `resolve_i` is high. They also assume that a hint and its resolve arrive in separate cycles, except when a fresh hint deliberately overlaps a resolve. The stimulus always presents a resolve with a full target. It asserts flush alone, without a concurrent hint or resolve. It sweeps every slot through miss, confirm, wrong-guess, aliasing and flush sequences, and compares each cycle against a reference table that the bench builds from the requirements.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

    // outcome of comparing an offered guess with the real target
    typedef enum logic [1:0] {
        VERD_IDLE    = 2'd0,
        VERD_CONFIRM = 2'd1,
        VERD_COLD    = 2'd2,
        VERD_WRONG   = 2'd3
    } verdict_t;

endpackage

// File: rtl/ftp_key_split.sv
module ftp_key_split #(
    parameter int AW    = 16,
    parameter int IDX_W = 4
) (
    input  logic [AW-1:0]         addr_i,
    output logic [IDX_W-1:0]      slot_o,
    output logic [AW-IDX_W-2:0]   tag_o
);
    // bit 0 is dropped: instruction words are 2-byte aligned
    assign slot_o = addr_i[IDX_W:1];
    assign tag_o  = addr_i[AW-1:IDX_W+1];
endmodule

// File: rtl/ftp_table.sv
module ftp_table #(
    parameter int AW      = 16,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = AW - IDX_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [IDX_W-1:0] rd_slot_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    output logic             rd_hit_o,
    output logic [AW-1:0]    rd_target_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_slot_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [AW-1:0]    wr_target_i
);
    typedef struct packed {
        logic             live;
        logic [TAG_W-1:0] tag;
        logic [AW-1:0]    dest;
    } slot_t;

    slot_t view [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        slot_t cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (flush_i) begin
                cell_d.live = 1'b0;
            end else if (wr_en_i && (wr_slot_i == IDX_W'(e))) begin
                cell_d.live = 1'b1;
                cell_d.tag  = wr_tag_i;
                cell_d.dest = wr_target_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end

        assign view[e] = cell_q;
    end

    slot_t picked;
    always_comb begin
        picked      = view[rd_slot_i];
        rd_hit_o    = picked.live && (picked.tag == rd_tag_i);
        rd_target_o = picked.dest;
    end
endmodule

// File: rtl/ftp_verify.sv
module ftp_verify
    import ftp_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          resolve_i,
    input  logic          waiting_i,
    input  logic          offered_i,
    input  logic [AW-1:0] offered_addr_i,
    input  logic [AW-1:0] actual_i,
    output verdict_t      verdict_o,
    output logic          train_o,
    output logic          restart_o
);
    always_comb begin
        verdict_o = VERD_IDLE;
        if (resolve_i && waiting_i) begin
            if (!offered_i)                     verdict_o = VERD_COLD;
            else if (offered_addr_i == actual_i) verdict_o = VERD_CONFIRM;
            else                                verdict_o = VERD_WRONG;
        end
        train_o   = (verdict_o == VERD_COLD) || (verdict_o == VERD_WRONG);
        restart_o = (verdict_o == VERD_WRONG);
    end
endmodule

// File: rtl/flow_target_predictor.sv
module flow_target_predictor
    import ftp_pkg::*;
#(
    parameter int AW      = 16,
    parameter int ENTRIES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          hint_i,
    input  logic [AW-1:0] pc_i,
    input  logic          resolve_i,
    input  logic [AW-1:0] target_i,
    output logic          predict_valid_o,
    output logic [AW-1:0] predict_addr_o,
    output logic          mispredict_o
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = AW - IDX_W - 1;

    typedef struct packed {
        logic             waiting;
        logic             offered;
        logic [AW-1:0]    guess;
        logic [IDX_W-1:0] key_slot;
        logic [TAG_W-1:0] key_tag;
        logic             restart;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] pc_slot;
    logic [TAG_W-1:0] pc_tag;
    logic             rd_hit;
    logic [AW-1:0]    rd_target;
    verdict_t         verdict;
    logic             train, restart, wr_en, take_hint;

    ftp_key_split #(.AW(AW), .IDX_W(IDX_W)) u_split (
        .addr_i (pc_i),
        .slot_o (pc_slot),
        .tag_o  (pc_tag)
    );

    ftp_verify #(.AW(AW)) u_verify (
        .resolve_i      (resolve_i),
        .waiting_i      (ctl_q.waiting),
        .offered_i      (ctl_q.offered),
        .offered_addr_i (ctl_q.guess),
        .actual_i       (target_i),
        .verdict_o      (verdict),
        .train_o        (train),
        .restart_o      (restart)
    );

    assign wr_en     = train && !flush_i;
    assign take_hint = hint_i && (!ctl_q.waiting || resolve_i);

    ftp_table #(.AW(AW), .ENTRIES(ENTRIES)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .rd_slot_i   (pc_slot),
        .rd_tag_i    (pc_tag),
        .rd_hit_o    (rd_hit),
        .rd_target_o (rd_target),
        .wr_en_i     (wr_en),
        .wr_slot_i   (ctl_q.key_slot),
        .wr_tag_i    (ctl_q.key_tag),
        .wr_target_i (target_i)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.restart = 1'b0;
        if (flush_i) begin
            ctl_d.waiting = 1'b0;
            ctl_d.offered = 1'b0;
        end else begin
            if (verdict != VERD_IDLE) begin
                ctl_d.waiting = 1'b0;
                ctl_d.offered = 1'b0;
                ctl_d.restart = restart;
            end
            if (take_hint) begin
                ctl_d.waiting  = 1'b1;
                ctl_d.offered  = rd_hit;
                ctl_d.guess    = rd_target;
                ctl_d.key_slot = pc_slot;
                ctl_d.key_tag  = pc_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign predict_valid_o = ctl_q.offered;
    assign predict_addr_o  = ctl_q.guess;
    assign mispredict_o    = ctl_q.restart;
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_i,
    input logic          hint_i,
    input logic          resolve_i,
    input logic          predict_valid_o,
    input logic [AW-1:0] predict_addr_o,
    input logic          mispredict_o
);
    // a restart pulse needs an offered guess and a resolve one cycle earlier
    p_restart_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_o |-> $past(predict_valid_o) && $past(resolve_i) && !$past(flush_i));

    // a resolve with nothing offered never requests a restart
    p_no_restart_unoffered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_i && !predict_valid_o) |=> !mispredict_o);

    // flush clears the outputs
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !predict_valid_o && !mispredict_o);

    // an offered guess holds while no resolve or flush arrives
    p_guess_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (predict_valid_o && !resolve_i && !flush_i) |=> predict_valid_o && $stable(predict_addr_o));

    // a new offer only follows a hint
    p_offer_needs_hint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(predict_valid_o) |-> $past(hint_i));
endmodule

bind flow_target_predictor ftp_checker #(.AW(AW)) u_ftp_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .flush_i         (flush_i),
    .hint_i          (hint_i),
    .resolve_i       (resolve_i),
    .predict_valid_o (predict_valid_o),
    .predict_addr_o  (predict_addr_o),
    .mispredict_o    (mispredict_o)
);

// File: tb/tb_flow_target_predictor.sv
module tb_flow_target_predictor;
    localparam int AW = 16;
    localparam int N  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0, hint_i = 1'b0, resolve_i = 1'b0;
    logic [AW-1:0] pc_i = '0, target_i = '0;
    logic          predict_valid_o, mispredict_o;
    logic [AW-1:0] predict_addr_o;

    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    flow_target_predictor #(.AW(AW), .ENTRIES(N)) dut (.*);

    // reference table built from the requirements
    bit            m_live [N];
    logic [10:0]   m_tag  [N];
    logic [AW-1:0] m_dest [N];
    bit            m_wait, m_off;
    logic [AW-1:0] m_guess;
    int            m_slot;
    logic [10:0]   m_ktag;

    function automatic logic [AW-1:0] mk_pc(int tag, int slot, int lsb);
        return AW'((tag << 5) | (slot << 1) | lsb);
    endfunction

    task automatic check(string req, bit ev, logic [AW-1:0] ea, bit em);
        tests++;
        if (predict_valid_o !== ev || mispredict_o !== em || (ev && predict_addr_o !== ea)) begin
            fails++;
            $display("FAIL %s: got valid=%0b addr=%h restart=%0b, expected valid=%0b addr=%h restart=%0b",
                     req, predict_valid_o, predict_addr_o, mispredict_o, ev, ea, em);
        end
    endtask

    // one clock of stimulus; expectation follows the rules R2..R11
    task automatic step(string req, bit h, logic [AW-1:0] p, bit r, logic [AW-1:0] t, bit f);
        bit em = 0;
        bit lk_hit = 0;
        logic [AW-1:0] lk_dest = '0;
        int ps = int'(p[4:1]);
        bit take = h && (!m_wait || r) && !f;
        if (take) begin
            lk_hit  = m_live[ps] && (m_tag[ps] == p[15:5]);
            lk_dest = m_dest[ps];
        end
        if (f) begin
            for (int i = 0; i < N; i++) m_live[i] = 0;
            m_wait = 0; m_off = 0;
        end else begin
            if (r && m_wait) begin
                em = m_off && (m_guess != t);
                if (!(m_off && m_guess == t)) begin
                    m_live[m_slot] = 1; m_tag[m_slot] = m_ktag; m_dest[m_slot] = t;
                end
                m_wait = 0; m_off = 0;
            end
            if (take) begin
                m_wait = 1; m_off = lk_hit; m_guess = lk_dest;
                m_slot = ps; m_ktag = p[15:5];
            end
        end
        hint_i = h; pc_i = p; resolve_i = r; target_i = t; flush_i = f;
        @(negedge clk);
        hint_i = 0; resolve_i = 0; flush_i = 0;
        check(req, m_off, m_guess, em);
    endtask

    function automatic logic [AW-1:0] tgt_a(int i); return AW'(16'h1000 + i * 16'h0132); endfunction
    function automatic logic [AW-1:0] tgt_b(int i); return AW'(16'h8004 + i * 16'h0226); endfunction

    initial begin
        for (int i = 0; i < N; i++) m_live[i] = 0;
        m_wait = 0; m_off = 0; m_guess = '0; m_slot = 0; m_ktag = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 0, '0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 0, '0, 0);

        // cold sweep: every slot misses, then trains
        for (int i = 0; i < N; i++) begin
            step("R3 cold lookup", 1, mk_pc(7, i, 0), 0, '0, 0);
            step("R3 cold resolve", 0, '0, 1, tgt_a(i), 0);
        end
        // warm sweep: hits, held, confirmed; odd slots probe with bit 0 set (R7)
        for (int i = 0; i < N; i++) begin
            step((i % 2) ? "R7 bit0 ignored" : "R2 warm lookup", 1, mk_pc(7, i, i % 2), 0, '0, 0);
            step("R4 guess held", 0, '0, 0, '0, 0);
            step("R5 confirm", 0, '0, 1, tgt_a(i), 0);
        end
        // wrong guesses: pulse, one cycle only, retrained
        for (int i = 0; i < N; i++) begin
            step("R4 hit", 1, mk_pc(7, i, 0), 0, '0, 0);
            step("R6 wrong guess", 0, '0, 1, tgt_b(i), 0);
            step("R6 pulse ends", 0, '0, 0, '0, 0);
            step("R6 retrained", 1, mk_pc(7, i, 0), 0, '0, 0);
            step("R5 confirm new", 0, '0, 1, tgt_b(i), 0);
        end
        // aliasing on every slot
        for (int i = 0; i < N; i++) begin
            step("R8 alias miss", 1, mk_pc(9, i, 0), 0, '0, 0);
            step("R8 alias train", 0, '0, 1, tgt_a(i) ^ 16'h00F0, 0);
            step("R8 evicted", 1, mk_pc(7, i, 0), 0, '0, 0);
            step("R8 restore", 0, '0, 1, tgt_b(i), 0);
        end
        // hint while waiting is ignored
        step("R11 first hint", 1, mk_pc(7, 0, 0), 0, '0, 0);
        step("R11 second hint ignored", 1, mk_pc(7, 1, 0), 0, '0, 0);
        step("R11 resolve first", 0, '0, 1, tgt_b(0), 0);
        // hint overlapping resolve is taken
        step("R2 hint", 1, mk_pc(7, 2, 0), 0, '0, 0);
        step("R2 hint with resolve", 1, mk_pc(7, 3, 0), 1, tgt_b(2), 0);
        step("R5 resolve overlap", 0, '0, 1, tgt_b(3), 0);
        // stray resolve is ignored
        step("R10 stray resolve", 0, '0, 1, 16'hDEAD, 0);
        step("R10 entry kept", 1, mk_pc(7, 4, 0), 0, '0, 0);
        step("R10 confirm", 0, '0, 1, tgt_b(4), 0);
        // flush with a pending guess, then everything misses
        step("R9 hint", 1, mk_pc(7, 5, 0), 0, '0, 0);
        step("R9 flush", 0, '0, 0, '0, 1);
        step("R9 resolve after flush", 0, '0, 1, 16'hBEEF, 0);
        for (int i = 0; i < N; i++) begin
            step("R9 all invalid", 1, mk_pc(7, i, 0), 0, '0, 0);
            step("R3 retrain", 0, '0, 1, tgt_a(i), 0);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: got hang, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule